// File: doc/BRIEF.md
# Bulk OUT Endpoint Ping-Pong Receive Store

This block is the receive-side packet store for one bulk OUT endpoint of a USB device controller. It has two packet slots of 64 bytes each. The packet receiver writes into them through start, byte-valid, end-of-packet and error strobes. A CPU or DMA engine empties them one byte at a time through a read port. The bytes appear on that port zero-extended to the width of the system bus.

Complete packets go to the reader in the order they arrived. Each slot stores the exact byte count of its packet, so a short packet or a zero-length packet is reported with its true size. After a good end-of-packet the block raises a service request, which is an interrupt or a DMA request depending on a mode input.

The block also tells the protocol engine to answer NAK whenever neither slot can take a new packet. That condition lasts until one slot has been drained completely. A packet that ends in error, or that runs past 64 bytes, is dropped and leaves no trace.

Top module: `bulk_rx_pp`

## Requirements
- R1: There are two slots of 64 bytes each. Complete packets are delivered in arrival order. `rd_avail` is high while the oldest complete packet is unread.
- R2: `rd_count` gives the exact byte count of the head packet, from 0 to 64. It reads 0 when nothing is available. `rd_last` is high while the byte on `rd_data` is the final byte of the head packet, and also for a zero-length packet.
- R3: `rd_data` holds the current head byte in bits 7:0, and every higher bit is zero. When no packet is available, `rd_data` is zero and `rd_en` has no effect. A `rd_en` pulse while `rd_avail` is high advances to the next byte.
- R4: A zero-length packet is reported with count 0 and is retired by a single `rd_en` pulse.
- R5: The service request is high from the cycle after a good end-of-packet for as long as any complete packet is unread. It drops in the cycle after the last byte of the last pending packet is read. `mode_dma` = 1 routes it to `dma_req`, and `mode_dma` = 0 routes it to `irq`. The two are never high together.
- R6: `nak` is high while both slots are occupied, where occupied means complete or being received. A slot that is only partly drained still counts as occupied. A `rx_start` that arrives while both slots are complete is ignored along with every byte of that packet.
- R7: `ack` pulses for one cycle, in the cycle after a good end-of-packet.
- R8: A packet is discarded in two cases: `rx_err` is seen while it is being received, or it carries more than 64 bytes. A discarded packet gives no `ack` and no service request, and its slot becomes free again.
- R9: After reset `rd_data`, `rd_avail`, `rd_count`, `rd_last`, `nak`, `ack`, `irq` and `dma_req` are all zero, and both slots are empty.
- R10: A byte is stored only in a cycle where `rx_valid` is high and `rx_start`, `rx_eop` and `rx_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_dma | input | 1 | 1 routes the service request to `dma_req`, 0 routes it to `irq` |
| rx_start | input | 1 | OUT token seen, a packet begins |
| rx_valid | input | 1 | `rx_data` carries a payload byte |
| rx_data | input | 8 | Received payload byte |
| rx_eop | input | 1 | Packet ended with good CRC |
| rx_err | input | 1 | Packet aborted or corrupt |
| ack | output | 1 | One-cycle handshake pulse for an accepted packet |
| nak | output | 1 | No free slot, answer the next OUT token with NAK |
| rd_en | input | 1 | Consume the current byte |
| rd_data | output | 32 | Head byte, zero-extended |
| rd_avail | output | 1 | A complete packet is ready |
| rd_count | output | 7 | Byte count of the head packet |
| rd_last | output | 1 | Current byte is the final byte of the head packet |
| irq | output | 1 | Service request in interrupt mode |
| dma_req | output | 1 | Service request in DMA mode |

## Verification
A read or write pointer that swaps slots out of turn shows up at once: `rd_data` presents bytes from the wrong packet, or `rd_count` reports the wrong length, in the first cycle after the slot changes. A slot state that goes wrong leaves `nak` or the service request set or cleared one cycle off from the reference, or lets a rejected or discarded packet show up on `rd_avail`. The bench compares every output against a queue-based model after every clock edge, so any such divergence is reported in the cycle where it first appears.

// File: rtl/bulk_rx_pkg.sv
package bulk_rx_pkg;
   localparam int NSLOT = 2;

   typedef enum logic [1:0] {
      SLOT_EMPTY = 2'd0,
      SLOT_FILL  = 2'd1,
      SLOT_FULL  = 2'd2
   } slot_st_t;
endpackage

// File: rtl/bulk_rx_slot.sv
module bulk_rx_slot
   import bulk_rx_pkg::*;
#(
   parameter int PKT_BYTES = 64,
   parameter int CNT_W     = $clog2(PKT_BYTES + 1),
   parameter int IDX_W     = $clog2(PKT_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_i,
   input  logic             wr_en_i,
   input  logic [7:0]       wr_data_i,
   input  logic             close_i,
   input  logic             abort_i,
   input  logic             rd_en_i,
   output slot_st_t         st_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic [7:0]       byte_o,
   output logic             last_o,
   output logic             ovf_o
);
   logic [7:0]       mem [PKT_BYTES];
   slot_st_t         st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [IDX_W-1:0] rdi_q;
   logic             ovf_q;
   logic             at_cap;
   logic             store;

   assign at_cap = (cnt_q == CNT_W'(PKT_BYTES));
   assign store  = wr_en_i && (st_q == SLOT_FILL) && !at_cap;
   assign last_o = (cnt_q == '0) || (CNT_W'(rdi_q) == cnt_q - CNT_W'(1));

   always_ff @(posedge clk) begin
      if (store) mem[cnt_q[IDX_W-1:0]] <= wr_data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SLOT_EMPTY;
         cnt_q <= '0;
         rdi_q <= '0;
         ovf_q <= 1'b0;
      end else if (abort_i) begin
         st_q <= SLOT_EMPTY;
      end else if (open_i) begin
         st_q  <= SLOT_FILL;
         cnt_q <= '0;
         rdi_q <= '0;
         ovf_q <= 1'b0;
      end else if (close_i) begin
         st_q <= ovf_q ? SLOT_EMPTY : SLOT_FULL;
      end else if (wr_en_i && st_q == SLOT_FILL) begin
         if (at_cap) ovf_q <= 1'b1;
         else        cnt_q <= cnt_q + CNT_W'(1);
      end else if (rd_en_i && st_q == SLOT_FULL) begin
         if (last_o) begin
            st_q  <= SLOT_EMPTY;
            rdi_q <= '0;
         end else begin
            rdi_q <= rdi_q + IDX_W'(1);
         end
      end
   end

   assign st_o   = st_q;
   assign cnt_o  = cnt_q;
   assign byte_o = mem[rdi_q];
   assign ovf_o  = ovf_q;
endmodule

// File: rtl/bulk_rx_wrctl.sv
module bulk_rx_wrctl
   import bulk_rx_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_start,
   input  logic             rx_valid,
   input  logic             rx_eop,
   input  logic             rx_err,
   input  slot_st_t         st_i   [NSLOT],
   input  logic [NSLOT-1:0] ovf_i,
   output logic [NSLOT-1:0] open_o,
   output logic [NSLOT-1:0] wr_en_o,
   output logic [NSLOT-1:0] close_o,
   output logic [NSLOT-1:0] abort_o,
   output logic             ack_o,
   output logic             nak_o
);
   logic wr_sel_q;
   logic filling_q;
   logic accept;
   logic good;
   logic ack_q;

   assign accept = rx_start && (st_i[wr_sel_q] != SLOT_FULL);
   assign good   = filling_q && !rx_start && !rx_err && rx_eop && !ovf_i[wr_sel_q];

   always_comb begin
      open_o  = '0;
      wr_en_o = '0;
      close_o = '0;
      abort_o = '0;
      if (rx_start) begin
         if (accept) open_o[wr_sel_q] = 1'b1;
      end else if (filling_q) begin
         if (rx_err)        abort_o[wr_sel_q] = 1'b1;
         else if (rx_eop)   close_o[wr_sel_q] = 1'b1;
         else if (rx_valid) wr_en_o[wr_sel_q] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_sel_q  <= 1'b0;
         filling_q <= 1'b0;
         ack_q     <= 1'b0;
      end else begin
         if (rx_start) filling_q <= accept;
         else if (rx_err || rx_eop) filling_q <= 1'b0;
         if (good) wr_sel_q <= ~wr_sel_q;
         ack_q <= good;
      end
   end

   assign ack_o = ack_q;
   assign nak_o = (st_i[0] != SLOT_EMPTY) && (st_i[1] != SLOT_EMPTY);
endmodule

// File: rtl/bulk_rx_rdsel.sv
module bulk_rx_rdsel
   import bulk_rx_pkg::*;
#(
   parameter int BUS_W = 32,
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_dma,
   input  logic             rd_en,
   input  slot_st_t         st_i   [NSLOT],
   input  logic [CNT_W-1:0] cnt_i  [NSLOT],
   input  logic [7:0]       byte_i [NSLOT],
   input  logic [NSLOT-1:0] last_i,
   output logic [NSLOT-1:0] rd_en_o,
   output logic [BUS_W-1:0] rd_data,
   output logic             rd_avail,
   output logic [CNT_W-1:0] rd_count,
   output logic             rd_last,
   output logic             irq,
   output logic             dma_req
);
   logic       rd_sel_q;
   logic       avail;
   logic       svc;
   logic [7:0] hbyte;

   assign avail    = (st_i[rd_sel_q] == SLOT_FULL);
   assign rd_en_o  = (rd_en && avail) ? (NSLOT'(1) << rd_sel_q) : '0;
   assign hbyte    = (avail && cnt_i[rd_sel_q] != '0) ? byte_i[rd_sel_q] : 8'h00;
   assign rd_avail = avail;
   assign rd_count = avail ? cnt_i[rd_sel_q] : '0;
   assign rd_last  = avail && last_i[rd_sel_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             rd_sel_q <= 1'b0;
      else if (rd_en && avail && last_i[rd_sel_q]) rd_sel_q <= ~rd_sel_q;
   end

   generate
      if (BUS_W == 8) begin : g_narrow
         assign rd_data = hbyte;
      end else begin : g_wide
         assign rd_data = {{(BUS_W-8){1'b0}}, hbyte};
      end
   endgenerate

   assign svc     = (st_i[0] == SLOT_FULL) || (st_i[1] == SLOT_FULL);
   assign irq     = svc && !mode_dma;
   assign dma_req = svc && mode_dma;
endmodule

// File: rtl/bulk_rx_pp.sv
module bulk_rx_pp
   import bulk_rx_pkg::*;
#(
   parameter  int BUS_W     = 32,
   parameter  int PKT_BYTES = 64,
   localparam int CNT_W     = $clog2(PKT_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_dma,
   input  logic             rx_start,
   input  logic             rx_valid,
   input  logic [7:0]       rx_data,
   input  logic             rx_eop,
   input  logic             rx_err,
   output logic             ack,
   output logic             nak,
   input  logic             rd_en,
   output logic [BUS_W-1:0] rd_data,
   output logic             rd_avail,
   output logic [CNT_W-1:0] rd_count,
   output logic             rd_last,
   output logic             irq,
   output logic             dma_req
);
   localparam int IDX_W = $clog2(PKT_BYTES);

   generate
      if (PKT_BYTES < 2 || (PKT_BYTES & (PKT_BYTES - 1)) != 0) begin : g_bad_depth
         $error("bulk_rx_pp: PKT_BYTES must be a power of two >= 2");
      end
      if (BUS_W < 8) begin : g_bad_bus
         $error("bulk_rx_pp: BUS_W must be at least 8");
      end
   endgenerate

   slot_st_t         st    [NSLOT];
   logic [CNT_W-1:0] cnt   [NSLOT];
   logic [7:0]       sbyte [NSLOT];
   logic [NSLOT-1:0] last, ovf, open_v, wr_en_v, close_v, abort_v, rd_en_v;

   bulk_rx_wrctl u_wrctl (
      .clk(clk), .rst_n(rst_n),
      .rx_start(rx_start), .rx_valid(rx_valid), .rx_eop(rx_eop), .rx_err(rx_err),
      .st_i(st), .ovf_i(ovf),
      .open_o(open_v), .wr_en_o(wr_en_v), .close_o(close_v), .abort_o(abort_v),
      .ack_o(ack), .nak_o(nak)
   );

   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      bulk_rx_slot #(.PKT_BYTES(PKT_BYTES), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_slot (
         .clk(clk), .rst_n(rst_n),
         .open_i(open_v[g]), .wr_en_i(wr_en_v[g]), .wr_data_i(rx_data),
         .close_i(close_v[g]), .abort_i(abort_v[g]), .rd_en_i(rd_en_v[g]),
         .st_o(st[g]), .cnt_o(cnt[g]), .byte_o(sbyte[g]),
         .last_o(last[g]), .ovf_o(ovf[g])
      );
   end

   bulk_rx_rdsel #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_rdsel (
      .clk(clk), .rst_n(rst_n), .mode_dma(mode_dma), .rd_en(rd_en),
      .st_i(st), .cnt_i(cnt), .byte_i(sbyte), .last_i(last),
      .rd_en_o(rd_en_v), .rd_data(rd_data), .rd_avail(rd_avail),
      .rd_count(rd_count), .rd_last(rd_last), .irq(irq), .dma_req(dma_req)
   );
endmodule

// File: rtl/bulk_rx_chk.sv
module bulk_rx_chk #(
   parameter  int BUS_W     = 32,
   parameter  int PKT_BYTES = 64,
   localparam int CNT_W     = $clog2(PKT_BYTES + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_eop,
   input logic             rx_err,
   input logic             ack,
   input logic             nak,
   input logic             rd_en,
   input logic [BUS_W-1:0] rd_data,
   input logic             rd_avail,
   input logic [CNT_W-1:0] rd_count,
   input logic             rd_last,
   input logic             irq,
   input logic             dma_req
);
   logic svc;
   assign svc = irq || dma_req;

   a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      rd_count <= CNT_W'(PKT_BYTES));

   a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_avail |-> (rd_data == '0 && rd_count == '0 && !rd_last));

   a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data >> 8) == '0);

   a_r5_one_request: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq && dma_req));

   a_r5_req_needs_pkt: assert property (@(posedge clk) disable iff (!rst_n)
      svc |-> rd_avail);

   a_r5_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(svc) |-> $past(rd_en && rd_last));

   a_r6_nak_release: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nak) |-> ($past(rd_en && rd_avail && rd_last) || $past(rx_err || rx_eop)));

   a_r7_ack_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> $past(rx_eop));
endmodule

bind bulk_rx_pp bulk_rx_chk #(.BUS_W(BUS_W), .PKT_BYTES(PKT_BYTES)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_eop(rx_eop), .rx_err(rx_err),
   .ack(ack), .nak(nak), .rd_en(rd_en), .rd_data(rd_data),
   .rd_avail(rd_avail), .rd_count(rd_count), .rd_last(rd_last),
   .irq(irq), .dma_req(dma_req)
);

// File: tb/bulk_rx_pp_bench.sv
module bulk_rx_pp_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_dma = 1'b0;
   logic        rx_start = 1'b0, rx_valid = 1'b0, rx_eop = 1'b0, rx_err = 1'b0;
   logic [7:0]  rx_data = 8'h00;
   logic        rd_en = 1'b0;
   logic        ack, nak, rd_avail, rd_last, irq, dma_req;
   logic [31:0] rd_data;
   logic [6:0]  rd_count;

   int checks = 0;
   int errors = 0;
   bit cmp_on = 1'b0;

   always #5 clk = ~clk;

   bulk_rx_pp u_bulk_rx_pp (
      .clk(clk), .rst_n(rst_n), .mode_dma(mode_dma),
      .rx_start(rx_start), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_eop(rx_eop), .rx_err(rx_err), .ack(ack), .nak(nak),
      .rd_en(rd_en), .rd_data(rd_data), .rd_avail(rd_avail),
      .rd_count(rd_count), .rd_last(rd_last), .irq(irq), .dma_req(dma_req)
   );

   // behavioural reference: queues of completed packets
   int data_q[$];
   int len_q[$];
   int cur_q[$];
   bit filling = 1'b0, ovf = 1'b0, ack_exp = 1'b0, acc;
   int head_rd = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         data_q.delete(); len_q.delete(); cur_q.delete();
         filling = 0; ovf = 0; ack_exp = 0; head_rd = 0;
      end else begin
         acc = (len_q.size() < 2);
         ack_exp = 0;
         if (rd_en && len_q.size() > 0) begin
            if (len_q[0] == 0) begin
               void'(len_q.pop_front());
            end else begin
               void'(data_q.pop_front());
               head_rd++;
               if (head_rd == len_q[0]) begin
                  void'(len_q.pop_front());
                  head_rd = 0;
               end
            end
         end
         if (rx_start) begin
            filling = acc; cur_q.delete(); ovf = 0;
         end else if (filling) begin
            if (rx_err) filling = 0;
            else if (rx_eop) begin
               filling = 0;
               if (!ovf) begin
                  foreach (cur_q[i]) data_q.push_back(cur_q[i]);
                  len_q.push_back(cur_q.size());
                  ack_exp = 1;
               end
            end else if (rx_valid) begin
               if (cur_q.size() == 64) ovf = 1;
               else cur_q.push_back(int'(rx_data));
            end
         end
      end
   end

   task automatic cmp(string req, string nm, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, nm, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      #2;
      if (cmp_on) begin
         bit av;
         int ln;
         av = (len_q.size() > 0);
         ln = av ? len_q[0] : 0;
         cmp("R1", "rd_avail", int'(rd_avail), int'(av));
         cmp("R2", "rd_count", int'(rd_count), ln);
         cmp("R2", "rd_last", int'(rd_last), int'(av && (ln == 0 || head_rd == ln - 1)));
         cmp("R3", "rd_data", int'(rd_data), (av && ln > 0) ? data_q[0] : 0);
         cmp("R6", "nak", int'(nak), int'(len_q.size() + int'(filling) >= 2));
         cmp("R5", "irq", int'(irq), int'(av && !mode_dma));
         cmp("R5", "dma_req", int'(dma_req), int'(av && mode_dma));
         cmp("R7", "ack", int'(ack), int'(ack_exp));
      end
   end

   task automatic tick();
      @(negedge clk);
   endtask

   // bad: 0 = good eop, 1 = error end; extra_valid holds rx_valid in eop cycle
   task automatic send_pkt(int n, int base, bit bad, bit extra_valid);
      @(negedge clk);
      rx_start = 1; tick(); rx_start = 0;
      for (int i = 0; i < n; i++) begin
         rx_valid = 1; rx_data = 8'(base + i); tick();
      end
      rx_valid = extra_valid; rx_data = 8'hEE;
      if (bad) rx_err = 1; else rx_eop = 1;
      tick();
      rx_valid = 0; rx_eop = 0; rx_err = 0;
   endtask

   task automatic drain(int n);
      @(negedge clk);
      for (int i = 0; i < n; i++) begin
         rd_en = 1; tick();
      end
      rd_en = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      cmp("R9", "rd_data", int'(rd_data), 0);
      cmp("R9", "rd_avail", int'(rd_avail), 0);
      cmp("R9", "nak", int'(nak), 0);
      cmp("R9", "irq_dma_ack", int'({irq, dma_req, ack}), 0);
      rst_n = 1;
      tick();
      cmp_on = 1;
      // R1 R2: full 64-byte packet
      send_pkt(64, 8'h10, 0, 0);
      repeat (2) tick();
      drain(64);
      // R4 R5: DMA mode, short packet then zero-length
      mode_dma = 1;
      send_pkt(10, 8'h80, 0, 0);
      send_pkt(0, 0, 0, 0);
      drain(10);
      drain(1);
      mode_dma = 0;
      // R6: both slots complete, third packet refused
      send_pkt(20, 8'h20, 0, 0);
      send_pkt(30, 8'h40, 0, 0);
      send_pkt(5, 8'hA0, 0, 0);
      drain(10);
      tick();
      cmp("R6", "nak_after_partial", int'(nak), 1);
      drain(10);
      drain(30);
      tick();
      cmp("R6", "refused_not_stored", int'(rd_avail), 0);
      // R8: error end and overflow
      send_pkt(8, 8'h55, 1, 0);
      send_pkt(65, 8'h00, 0, 0);
      tick();
      cmp("R8", "discarded_avail", int'(rd_avail), 0);
      // R1: read while receiving
      send_pkt(16, 8'hC0, 0, 0);
      fork
         send_pkt(40, 8'h60, 0, 0);
         drain(16);
      join
      drain(40);
      // R3: reads with nothing pending
      drain(4);
      // R10: rx_valid in the eop cycle is not stored
      send_pkt(3, 8'h31, 0, 1);
      tick();
      cmp("R10", "count_eop_byte", int'(rd_count), 3);
      drain(3);
      repeat (3) tick();
      cmp_on = 0;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule